// File: doc/BRIEF.md
# DLL Lane Enable Sequencer

This block brings the delay-locked loops of a DDR memory interface out of reset once a phase setting has been chosen. It controls one master clock-delay DLL and a set of per-byte-lane DQS DLLs. Each DLL has a disable bit, an active-low reset bit and a phase field. Every DLL passes through the same three steps. In the first step it is disabled and held in reset. In the second step it is enabled but still held in reset. In the third step it is released and runs. Each step lasts a fixed number of microsecond ticks.

The master DLL completes all three of its steps before any lane DLL moves. The active lanes then go through the steps in lockstep. A bus-width select chooses how many lanes take part. The wide setting uses four lanes and the narrow setting uses two. Lanes that do not take part stay disabled and in reset with a zero phase.

A single-cycle start request begins a run. All phases come from one packed phase word, and the word and the width are captured when the start is accepted. A single-cycle done pulse marks the end of the last wait.

Top module: `dll_bringup_seq`

## Requirements
- R1: After reset, every DLL shows disable=1 and reset_n=0 with phase 0, and done is 0. Nothing changes until a start is accepted, however many ticks arrive.
- R2: When a start is accepted, the master phase output takes phase word bits [21:16]. Active lane k (k=0..3) takes word bits [4k+3:4k].
- R3: Hold step: the DLL shows disable=1 and reset_n=0 for exactly 2 ticks, counted after the cycle in which the step was entered.
- R4: Settle step: disable=0 and reset_n=0 for exactly 22 ticks.
- R5: Run step: disable=0 and reset_n=1 for 22 ticks. The DLL keeps these values after the sequence ends.
- R6: No lane leaves the held-off state until the master has finished its run-step wait (46 ticks after start). All active lanes change together.
- R7: With wide_bus=1 at start, lanes 0..3 are sequenced. With wide_bus=0, only lanes 0..1 are sequenced. Lanes 2..3 then stay disable=1, reset_n=0, phase 0.
- R8: A start request while a run is in progress is ignored. Changes to the phase word or the width during a run have no effect on the outputs.
- R9: done is high for exactly one cycle. It follows the clock edge that consumes the 92nd tick after start, which is the end of the lanes' run-step wait.
- R10: A start accepted after completion restarts the sequence. The master returns to the hold step and every lane returns to the held-off state with new phases.
- R11: The sequence advances only on ticks. Clock cycles without a tick never shorten or end a step, and a tick in the start cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Single-cycle request to begin a bring-up run |
| wide_bus_i | input | 1 | 1 selects four lanes, 0 selects two; sampled at start |
| phase_word_i | input | 22 | Packed phases: master at [21:16], lane k at [4k+3:4k] |
| us_tick_i | input | 1 | One-cycle strobe, once per microsecond |
| mst_dis_o | output | 1 | Master DLL disable |
| mst_rst_n_o | output | 1 | Master DLL active-low reset |
| mst_phase_o | output | 6 | Master DLL phase |
| lane_dis_o | output | 4 | Lane DLL disables, bit k for lane k |
| lane_rst_n_o | output | 4 | Lane DLL active-low resets |
| lane_phase_o | output | 16 | Lane phases, lane k at [4k+3:4k] |
| done_o | output | 1 | One-cycle pulse at the end of the sequence |

## Verification
The assertions assume that the tick is a clean strobe and that start and width are synchronous single-bit inputs held steady around the clock edge. They make no assumption about how far apart ticks are. The stimulus changes inputs only at the falling edge. It uses several tick spacings, including a tick every cycle and long gaps with no tick, and it places a start on the cycle right after done. Width and phase inputs are changed during runs, and extra starts are issued during runs, so that the ignored inputs are exercised while the assertions watch the lockstep and release order.

// File: rtl/dll_seq_pkg.sv
package dll_seq_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD   = 2'd0,
    STEP_SETTLE = 2'd1,
    STEP_RUN    = 2'd2
  } step_e;

  typedef enum logic [2:0] {
    SQ_IDLE     = 3'd0,
    SQ_M_HOLD   = 3'd1,
    SQ_M_SETTLE = 3'd2,
    SQ_M_RUN    = 3'd3,
    SQ_L_HOLD   = 3'd4,
    SQ_L_SETTLE = 3'd5,
    SQ_L_RUN    = 3'd6
  } seq_e;

  function automatic step_e step_of(input seq_e s);
    case (s)
      SQ_M_HOLD, SQ_L_HOLD:     step_of = STEP_HOLD;
      SQ_M_SETTLE, SQ_L_SETTLE: step_of = STEP_SETTLE;
      default:                  step_of = STEP_RUN;
    endcase
  endfunction

  function automatic logic is_lane_stage(input seq_e s);
    is_lane_stage = (s == SQ_L_HOLD) || (s == SQ_L_SETTLE) || (s == SQ_L_RUN);
  endfunction

endpackage

// File: rtl/dll_hold_timer.sv
module dll_hold_timer #(
  parameter int SHORT_TICKS = 2,
  parameter int LONG_TICKS  = 22
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  input  logic tick,
  input  logic long_sel,
  output logic expire
);
  localparam int CNT_W = $clog2(LONG_TICKS + 1);
  localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_TICKS);
  localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_TICKS);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit  = long_sel ? LONG_LIM : SHORT_LIM;
  assign expire = run && tick && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (run && tick) cnt <= cnt + 1'b1;
  end

  // Count never passes the length of the current step
  assert_count_in_window_R4: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < limit));

endmodule

// File: rtl/dll_seq_ctrl.sv
module dll_seq_ctrl
  import dll_seq_pkg::*;
#(
  parameter int SHORT_TICKS = 2,
  parameter int LONG_TICKS  = 22
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  logic  tick,
  output logic  launch,
  output logic  apply,
  output logic  apply_lane,
  output step_e apply_step,
  output logic  done
);
  seq_e state, nxt;
  logic expire;
  logic finish;

  always_comb begin
    nxt    = state;
    finish = 1'b0;
    launch = 1'b0;
    if (state == SQ_IDLE) begin
      if (start) begin
        nxt    = SQ_M_HOLD;
        launch = 1'b1;
      end
    end else if (expire) begin
      case (state)
        SQ_M_HOLD:   nxt = SQ_M_SETTLE;
        SQ_M_SETTLE: nxt = SQ_M_RUN;
        SQ_M_RUN:    nxt = SQ_L_HOLD;
        SQ_L_HOLD:   nxt = SQ_L_SETTLE;
        SQ_L_SETTLE: nxt = SQ_L_RUN;
        default: begin
          nxt    = SQ_IDLE;
          finish = 1'b1;
        end
      endcase
    end
  end

  assign apply      = (nxt != state) && (nxt != SQ_IDLE);
  assign apply_lane = is_lane_stage(nxt);
  assign apply_step = step_of(nxt);

  dll_hold_timer #(
    .SHORT_TICKS(SHORT_TICKS),
    .LONG_TICKS (LONG_TICKS)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (nxt != state),
    .run     (state != SQ_IDLE),
    .tick    (tick),
    .long_sel(step_of(state) != STEP_HOLD),
    .expire  (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= finish;
    end
  end

  // Busy and no expiry: the stage holds (extra starts and idle clocks do nothing)
  assert_stage_waits_tick_R11: assert property (@(posedge clk) disable iff (rst)
    (state != SQ_IDLE && !expire) |=> $stable(state));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/dll_ctl_drv.sv
module dll_ctl_drv
  import dll_seq_pkg::*;
#(
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               launch,
  input  logic               phase_en,
  input  logic [PHASE_W-1:0] phase_in,
  input  logic               apply,
  input  step_e              step,
  output logic               dis,
  output logic               rst_n,
  output logic [PHASE_W-1:0] phase
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dis   <= 1'b1;
      rst_n <= 1'b0;
      phase <= '0;
    end else begin
      if (launch) phase <= phase_en ? phase_in : '0;
      if (apply) begin
        case (step)
          STEP_HOLD:   begin dis <= 1'b1; rst_n <= 1'b0; end
          STEP_SETTLE: begin dis <= 1'b0; rst_n <= 1'b0; end
          default:     begin dis <= 1'b0; rst_n <= 1'b1; end
        endcase
      end else if (launch) begin
        dis   <= 1'b1;
        rst_n <= 1'b0;
      end
    end
  end

  // Reset is released only once the DLL was already enabled
  assert_release_after_enable_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n) |-> !$past(dis));

  assert_phase_held_R2: assert property (@(posedge clk) disable iff (rst)
    !launch |=> $stable(phase));

endmodule

// File: rtl/dll_bringup_seq.sv
module dll_bringup_seq
  import dll_seq_pkg::*;
#(
  parameter int NUM_DLL_WIDE   = 5,
  parameter int NUM_DLL_NARROW = 3,
  parameter int MST_PHASE_W    = 6,
  parameter int MST_PHASE_LSB  = 16,
  parameter int LANE_PHASE_W   = 4,
  parameter int HOLD_SHORT_US  = 2,
  parameter int HOLD_LONG_US   = 22,
  localparam int NUM_LANES     = NUM_DLL_WIDE - 1,
  localparam int NARROW_LANES  = NUM_DLL_NARROW - 1,
  localparam int WORD_W        = MST_PHASE_LSB + MST_PHASE_W
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start_i,
  input  logic                           wide_bus_i,
  input  logic [WORD_W-1:0]              phase_word_i,
  input  logic                           us_tick_i,
  output logic                           mst_dis_o,
  output logic                           mst_rst_n_o,
  output logic [MST_PHASE_W-1:0]         mst_phase_o,
  output logic [NUM_LANES-1:0]           lane_dis_o,
  output logic [NUM_LANES-1:0]           lane_rst_n_o,
  output logic [NUM_LANES*LANE_PHASE_W-1:0] lane_phase_o,
  output logic                           done_o
);
  logic  launch, apply, apply_lane;
  step_e apply_step;
  logic  wide_q;

  dll_seq_ctrl #(
    .SHORT_TICKS(HOLD_SHORT_US),
    .LONG_TICKS (HOLD_LONG_US)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start_i),
    .tick      (us_tick_i),
    .launch    (launch),
    .apply     (apply),
    .apply_lane(apply_lane),
    .apply_step(apply_step),
    .done      (done_o)
  );

  always_ff @(posedge clk) begin
    if (rst) wide_q <= 1'b0;
    else if (launch) wide_q <= wide_bus_i;
  end

  dll_ctl_drv #(.PHASE_W(MST_PHASE_W)) u_mst (
    .clk     (clk),
    .rst     (rst),
    .launch  (launch),
    .phase_en(1'b1),
    .phase_in(phase_word_i[MST_PHASE_LSB +: MST_PHASE_W]),
    .apply   (apply && !apply_lane),
    .step    (apply_step),
    .dis     (mst_dis_o),
    .rst_n   (mst_rst_n_o),
    .phase   (mst_phase_o)
  );

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    localparam bit ALWAYS_ON = (i < NARROW_LANES);
    logic load_en, run_en;
    assign load_en = ALWAYS_ON || wide_bus_i;
    assign run_en  = ALWAYS_ON || wide_q;

    dll_ctl_drv #(.PHASE_W(LANE_PHASE_W)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .launch  (launch),
      .phase_en(load_en),
      .phase_in(phase_word_i[i*LANE_PHASE_W +: LANE_PHASE_W]),
      .apply   (apply && apply_lane && run_en),
      .step    (apply_step),
      .dis     (lane_dis_o[i]),
      .rst_n   (lane_rst_n_o[i]),
      .phase   (lane_phase_o[i*LANE_PHASE_W +: LANE_PHASE_W])
    );

    if (!ALWAYS_ON) begin : g_opt
      assert_narrow_lane_off_R7: assert property (@(posedge clk) disable iff (rst)
        !wide_q |-> (lane_dis_o[i] && !lane_rst_n_o[i]));
    end

    assert_master_first_R6: assert property (@(posedge clk) disable iff (rst)
      !lane_dis_o[i] |-> mst_rst_n_o);
  end

  assert_lanes_lockstep_R6: assert property (@(posedge clk) disable iff (rst)
    ($countones(lane_dis_o[NARROW_LANES-1:0]) == 0) ||
    ($countones(lane_dis_o[NARROW_LANES-1:0]) == NARROW_LANES));

endmodule

// File: tb/dll_bringup_seq_bench.sv
module dll_bringup_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        wide_bus_i = 1'b0;
  logic [21:0] phase_word_i = '0;
  logic        us_tick_i = 1'b0;
  logic        mst_dis_o, mst_rst_n_o, done_o;
  logic [5:0]  mst_phase_o;
  logic [3:0]  lane_dis_o, lane_rst_n_o;
  logic [15:0] lane_phase_o;

  always #4 clk = ~clk;

  dll_bringup_seq u_dll_bringup_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .wide_bus_i(wide_bus_i),
    .phase_word_i(phase_word_i), .us_tick_i(us_tick_i),
    .mst_dis_o(mst_dis_o), .mst_rst_n_o(mst_rst_n_o), .mst_phase_o(mst_phase_o),
    .lane_dis_o(lane_dis_o), .lane_rst_n_o(lane_rst_n_o),
    .lane_phase_o(lane_phase_o), .done_o(done_o)
  );

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    finished = 0;

  // reference model state
  bit          m_busy = 0, m_ran = 0, m_wide = 0, m_done = 0;
  int          m_k = 0;
  logic [21:0] m_word = '0;

  function automatic logic [32:0] expect_vec();
    logic       md, mr;
    logic [5:0] mp;
    logic [3:0] ld, lr;
    logic [15:0] lp;
    md = 1; mr = 0; mp = '0; ld = '1; lr = '0; lp = '0;
    if (m_ran) begin
      mp = m_word[21:16];
      if (m_busy && m_k < 2)       begin md = 1; mr = 0; end
      else if (m_busy && m_k < 24) begin md = 0; mr = 0; end
      else                         begin md = 0; mr = 1; end
      for (int i = 0; i < 4; i++) begin
        if (i < 2 || m_wide) begin
          lp[i*4 +: 4] = m_word[i*4 +: 4];
          if (m_busy && m_k < 48)      begin ld[i] = 1; lr[i] = 0; end
          else if (m_busy && m_k < 70) begin ld[i] = 0; lr[i] = 0; end
          else                         begin ld[i] = 0; lr[i] = 1; end
        end
      end
    end
    return {md, mr, mp, ld, lr, lp, m_done};
  endfunction

  task automatic compare();
    logic [32:0] act, exp_v;
    act   = {mst_dis_o, mst_rst_n_o, mst_phase_o, lane_dis_o, lane_rst_n_o, lane_phase_o, done_o};
    exp_v = expect_vec();
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s k=%0d actual=%h expected=%h", cur_req, m_k, act, exp_v);
    end
  endtask

  task automatic cyc(input logic t, input logic s);
    us_tick_i = t;
    start_i   = s;
    @(posedge clk);
    m_done = 0;
    if (s && !m_busy) begin
      m_busy = 1; m_ran = 1; m_k = 0;
      m_word = phase_word_i; m_wide = wide_bus_i;
    end else if (m_busy && t) begin
      m_k++;
      if (m_k == 92) begin m_busy = 0; m_done = 1; end
    end
    @(negedge clk);
    compare();
    us_tick_i = 0;
    start_i   = 0;
  endtask

  // run with a tick every 'spacing' cycles until the model goes idle, plus tail
  task automatic run_out(input int spacing);
    int c = 0;
    while (m_busy && c < 5000) begin
      c++;
      cyc((c % spacing) == 0, 1'b0);
    end
    repeat (3) cyc(1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state, ticks alone change nothing
    cur_req = "R1";
    compare();
    repeat (20) cyc(1'b1, 1'b0);

    // R2 R3 R4 R5 R6: wide run, tick every 3 cycles
    cur_req = "R2/R3/R4/R5/R6";
    wide_bus_i = 1; phase_word_i = 22'h3F7C41;
    cyc(1'b1, 1'b1);           // R11: tick in start cycle not counted
    run_out(3);

    // R7 R8: narrow run, tick every cycle, inputs disturbed mid-run
    cur_req = "R7/R8";
    wide_bus_i = 0; phase_word_i = 22'h12D8C6;
    cyc(1'b0, 1'b1);
    for (int j = 0; j < 30; j++) cyc(1'b1, 1'b0);
    wide_bus_i = 1; phase_word_i = 22'h2AAAAA;
    cyc(1'b1, 1'b1);           // ignored start while busy
    for (int j = 0; j < 20; j++) cyc(1'b1, (j % 7) == 3);
    run_out(1);

    // R11: long gaps with no ticks inside the steps
    cur_req = "R11";
    wide_bus_i = 1; phase_word_i = 22'h05E93B;
    cyc(1'b0, 1'b1);
    cyc(1'b1, 1'b0);
    repeat (40) cyc(1'b0, 1'b0);
    for (int j = 0; j < 30; j++) cyc(1'b1, 1'b0);
    repeat (60) cyc(1'b0, 1'b0);
    run_out(5);

    // R9 R10: restart on the cycle right after done
    cur_req = "R9/R10";
    wide_bus_i = 0; phase_word_i = 22'h3B1F0E;
    cyc(1'b0, 1'b1);
    while (m_busy) cyc(1'b1, 1'b0);
    wide_bus_i = 1; phase_word_i = 22'h1C6257;
    cyc(1'b1, 1'b1);
    run_out(2);

    // near-exhaustive sweep of width and tick spacing
    for (int w = 0; w < 2; w++) begin
      for (int sp = 1; sp <= 4; sp++) begin
        cur_req = "R3/R4/R5/R7";
        wide_bus_i = w[0]; phase_word_i = 22'(w * 22'h155555 + sp * 22'h0A3C5);
        cyc(1'b0, 1'b1);
        run_out(sp);
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule